// File: doc/BRIEF.md
# Conflict-Free Middle Memory Selector

This block sits in a router that buffers flits in a bank of shared middle memories between two crossbars. Each flit has already been given a departure timestamp. Each cycle the selector takes up to `NUM_IN` such flits and gives each one a middle memory. Every memory accepts one write and one read per cycle. The chosen memory must therefore meet two conditions. No other flit from the same cycle may be written to it. It must not already hold a flit that leaves at the same timestamp, because two flits due out of one memory in the same cycle cannot both be read.

The selector keeps one occupancy bit per memory per timestamp slot. A grant sets the bit. A departure report from the read side clears it. Requests are served in input-index order, and each takes the lowest-numbered memory that is still eligible. When no memory is eligible, the request is answered with a failure. The flit then stays upstream and retries later with a new timestamp. With `NUM_MEM = 2*NUM_IN-1` and at most `NUM_IN-1` other flits sharing a timestamp, no request ever fails. Smaller banks trade occasional failures for area.

Answers are registered: a request presented before a clock edge is answered right after that edge. The occupancy table is updated at the same edge.

Top module: `mm_slot_picker`

## Requirements
- R1: After synchronous reset, all grant outputs and fail outputs are 0, every memory index output is 0, and every occupancy slot is free. The first request after reset therefore receives memory 0.
- R2: A request with `req_valid[i]=1` is answered in the next cycle. The answer is exactly one of `gnt_valid[i]=1` or `gnt_fail[i]=1`. A request with `req_valid[i]=0` gets `gnt_valid[i]=0`, `gnt_fail[i]=0` and `gnt_mem` field i equal to 0.
- R3: Requests are served in increasing input index. Each granted request gets the lowest-numbered memory that is free at its timestamp and not taken by a lower-indexed request in the same cycle. `gnt_mem` field i occupies bits `[i*MW +: MW]`, and `req_ts` field i occupies bits `[i*TS_W +: TS_W]`.
- R4: No two requests granted in the same cycle receive the same memory, whatever their timestamps.
- R5: A request is never granted a memory whose slot for the request's timestamp is occupied at the start of that cycle.
- R6: A grant marks the slot (memory, timestamp) as occupied from the next cycle onward.
- R7: `rel_valid[m]=1` frees the slot of memory m at timestamp `rel_ts[m*TS_W +: TS_W]` from the next cycle onward. A request in the same cycle still sees the slot as occupied. Releasing a slot that is already free has no effect.
- R8: A request with no eligible memory gets `gnt_fail[i]=1` and `gnt_mem` field i equal to 0. It changes no occupancy, so a retry after a release is granted.
- R9: A request is granted whenever the number of memories occupied at its timestamp, plus the number of lower-indexed valid requests in the same cycle, is less than `NUM_MEM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_IN | Per-input request flag |
| req_ts | input | NUM_IN*TS_W | Per-input departure timestamp |
| rel_valid | input | NUM_MEM | Per-memory departure report |
| rel_ts | input | NUM_MEM*TS_W | Timestamp of the departing flit, per memory |
| gnt_valid | output | NUM_IN | Registered grant flag per input |
| gnt_fail | output | NUM_IN | Registered failure flag per input |
| gnt_mem | output | NUM_IN*MW | Registered memory index per input, MW = clog2(NUM_MEM) |

## Verification
The first directed pattern sends five requests with one shared timestamp into an empty table. This separates correct index-order, lowest-memory assignment from any other ordering. Repeating the pattern fills the remaining memories and makes the last input fail. This shows the difference between departure conflicts with stored flits and arrival conflicts within one cycle. Sparse patterns with idle inputs check that gaps neither consume memories nor produce answers. A release issued in the same cycle as a matching request, followed by a retry, separates the old and new occupancy views and shows that a failure leaves no state behind. A long pseudo-random phase with narrow timestamps and random releases mixes all of these cases against a reference model in the bench.

// File: rtl/mmsel_pkg.sv
package mmsel_pkg;
  // Registered answer kind for one request lane
  typedef enum logic [1:0] {
    ANS_NONE  = 2'd0,
    ANS_GRANT = 2'd1,
    ANS_FAIL  = 2'd2
  } ans_e;
endpackage

// File: rtl/mmsel_lowest.sv
module mmsel_lowest #(
  parameter int W  = 9,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/mmsel_occ.sv
module mmsel_occ #(
  parameter int NUM_IN  = 5,
  parameter int NUM_MEM = 9,
  parameter int TS_W    = 4,
  parameter int MW      = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN*TS_W-1:0]    look_ts,
  output logic [NUM_IN*NUM_MEM-1:0] busy,
  input  logic [NUM_IN-1:0]         set_en,
  input  logic [NUM_IN*MW-1:0]      set_mem,
  input  logic [NUM_MEM-1:0]        clr_en,
  input  logic [NUM_MEM*TS_W-1:0]   clr_ts
);
  localparam int SLOTS = 1 << TS_W;

  logic [SLOTS-1:0] occ_q [NUM_MEM];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_look
    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
      assign busy[i*NUM_MEM + m] = occ_q[m][look_ts[i*TS_W +: TS_W]];
    end

    // R5: a grant never lands on an occupied slot
    p_free_slot_r5: assert property (@(posedge clk) disable iff (rst)
      set_en[i] |-> !occ_q[set_mem[i*MW +: MW]][look_ts[i*TS_W +: TS_W]]);

    // R6: a granted slot reads as occupied in the following cycle
    p_mark_slot_r6: assert property (@(posedge clk) disable iff (rst)
      set_en[i] |=> occ_q[$past(set_mem[i*MW +: MW])][$past(look_ts[i*TS_W +: TS_W])]);
  end

  // Releases first, grants second: a set of the same slot wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < NUM_MEM; m++) occ_q[m] <= '0;
    end else begin
      for (int m = 0; m < NUM_MEM; m++) begin
        if (clr_en[m]) occ_q[m][clr_ts[m*TS_W +: TS_W]] <= 1'b0;
      end
      for (int i = 0; i < NUM_IN; i++) begin
        if (set_en[i]) occ_q[set_mem[i*MW +: MW]][look_ts[i*TS_W +: TS_W]] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmsel_pick.sv
module mmsel_pick #(
  parameter int NUM_IN  = 5,
  parameter int NUM_MEM = 9,
  parameter int MW      = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic [NUM_IN-1:0]         req_valid,
  input  logic [NUM_IN*NUM_MEM-1:0] busy,
  output logic [NUM_IN-1:0]         grant,
  output logic [NUM_IN-1:0]         fail,
  output logic [NUM_IN*MW-1:0]      mem
);
  // claim[i]: memories already written by lanes below i this cycle
  logic [NUM_MEM-1:0] claim [NUM_IN+1];
  assign claim[0] = '0;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    logic [NUM_MEM-1:0] avail;
    logic               found;
    logic [MW-1:0]      idx;
    logic [NUM_MEM-1:0] take;

    assign avail = ~busy[i*NUM_MEM +: NUM_MEM] & ~claim[i];

    mmsel_lowest #(.W(NUM_MEM), .IW(MW)) u_low (
      .vec   (avail),
      .found (found),
      .idx   (idx)
    );

    assign grant[i]          = req_valid[i] & found;
    assign fail[i]           = req_valid[i] & ~found;
    assign mem[i*MW +: MW]   = grant[i] ? idx : '0;
    assign take              = grant[i] ? (NUM_MEM'(1) << idx) : '0;
    assign claim[i+1]        = claim[i] | take;
  end
endmodule

// File: rtl/mm_slot_picker.sv
module mm_slot_picker #(
  parameter int NUM_IN  = 5,
  parameter int NUM_MEM = 9,
  parameter int TS_W    = 4,
  parameter int MW      = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_IN-1:0]       req_valid,
  input  logic [NUM_IN*TS_W-1:0]  req_ts,
  input  logic [NUM_MEM-1:0]      rel_valid,
  input  logic [NUM_MEM*TS_W-1:0] rel_ts,
  output logic [NUM_IN-1:0]       gnt_valid,
  output logic [NUM_IN-1:0]       gnt_fail,
  output logic [NUM_IN*MW-1:0]    gnt_mem
);
  import mmsel_pkg::*;

  logic [NUM_IN*NUM_MEM-1:0] busy;
  logic [NUM_IN-1:0]         pick_grant;
  logic [NUM_IN-1:0]         pick_fail;
  logic [NUM_IN*MW-1:0]      pick_mem;

  ans_e                      ans_q [NUM_IN];
  logic [NUM_IN*MW-1:0]      mem_q;

  mmsel_occ #(.NUM_IN(NUM_IN), .NUM_MEM(NUM_MEM), .TS_W(TS_W), .MW(MW)) u_occ (
    .clk     (clk),
    .rst     (rst),
    .look_ts (req_ts),
    .busy    (busy),
    .set_en  (pick_grant),
    .set_mem (pick_mem),
    .clr_en  (rel_valid),
    .clr_ts  (rel_ts)
  );

  mmsel_pick #(.NUM_IN(NUM_IN), .NUM_MEM(NUM_MEM), .MW(MW)) u_pick (
    .req_valid (req_valid),
    .busy      (busy),
    .grant     (pick_grant),
    .fail      (pick_fail),
    .mem       (pick_mem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IN; i++) ans_q[i] <= ANS_NONE;
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IN; i++) begin
        if (pick_grant[i])     ans_q[i] <= ANS_GRANT;
        else if (pick_fail[i]) ans_q[i] <= ANS_FAIL;
        else                   ans_q[i] <= ANS_NONE;
      end
      mem_q <= pick_mem;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_out
    assign gnt_valid[i] = (ans_q[i] == ANS_GRANT);
    assign gnt_fail[i]  = (ans_q[i] == ANS_FAIL);

    // R2: every valid request is answered exactly once
    p_answer_r2: assert property (@(posedge clk) disable iff (rst)
      req_valid[i] |=> (gnt_valid[i] ^ gnt_fail[i]));

    // R2: an idle lane produces no answer
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !req_valid[i] |=> (!gnt_valid[i] && !gnt_fail[i] && gnt_mem[i*MW +: MW] == '0));

    // R3: lane 0 faces no arrival competition, so with an empty slot set it gets memory 0
    if (i == 0) begin : g_first
      p_first_low_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && !busy[0]) |=> (gnt_valid[0] && gnt_mem[0 +: MW] == '0));
    end

    for (genvar j = i + 1; j < NUM_IN; j++) begin : g_pair
      // R4: no two same-cycle grants share a memory
      p_distinct_r4: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid[i] && gnt_valid[j]) |-> (gnt_mem[i*MW +: MW] != gnt_mem[j*MW +: MW]));
    end
  end

  assign gnt_mem = mem_q;
endmodule

// File: tb/mm_slot_picker_tb.sv
module mm_slot_picker_tb;
  localparam int P     = 5;
  localparam int N     = 9;
  localparam int TW    = 4;
  localparam int MW    = $clog2(N);
  localparam int SLOTS = 1 << TW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [P-1:0]      req_valid = '0;
  logic [P*TW-1:0]   req_ts = '0;
  logic [N-1:0]      rel_valid = '0;
  logic [N*TW-1:0]   rel_ts = '0;
  logic [P-1:0]      gnt_valid;
  logic [P-1:0]      gnt_fail;
  logic [P*MW-1:0]   gnt_mem;

  always #5 clk = ~clk;

  mm_slot_picker #(.NUM_IN(P), .NUM_MEM(N), .TS_W(TW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ts    (req_ts),
    .rel_valid (rel_valid),
    .rel_ts    (rel_ts),
    .gnt_valid (gnt_valid),
    .gnt_fail  (gnt_fail),
    .gnt_mem   (gnt_mem)
  );

  typedef struct packed {
    logic [P-1:0]    v;
    logic [P-1:0]    f;
    logic [P*MW-1:0] m;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  bit    occ_m [N][SLOTS];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected answer
  task automatic drive(input logic [P-1:0] v, input logic [P*TW-1:0] ts,
                       input logic [N-1:0] rv, input logic [N*TW-1:0] rts,
                       input string tag);
    exp_t e;
    logic [N-1:0] claimed;
    @(negedge clk);
    req_valid = v; req_ts = ts; rel_valid = rv; rel_ts = rts;
    e = '0; claimed = '0;
    for (int i = 0; i < P; i++) begin
      if (v[i]) begin
        int t;
        bit hit;
        t = int'(ts[i*TW +: TW]);
        hit = 1'b0;
        for (int m = 0; m < N; m++) begin
          if (!hit && !occ_m[m][t] && !claimed[m]) begin
            hit = 1'b1;
            claimed[m] = 1'b1;
            e.v[i] = 1'b1;
            e.m[i*MW +: MW] = MW'(m);
          end
        end
        if (!hit) e.f[i] = 1'b1;
      end
    end
    for (int m = 0; m < N; m++)
      if (rv[m]) occ_m[m][int'(rts[m*TW +: TW])] = 1'b0;
    for (int i = 0; i < P; i++)
      if (e.v[i]) occ_m[int'(e.m[i*MW +: MW])][int'(ts[i*TW +: TW])] = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each answer one step after the edge that registers it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        for (int i = 0; i < P; i++) begin
          checks++;
          if (gnt_valid[i] !== e.v[i] || gnt_fail[i] !== e.f[i] ||
              gnt_mem[i*MW +: MW] !== e.m[i*MW +: MW]) begin
            errors++;
            $display("FAIL %s lane%0d: actual v=%0b f=%0b m=%0d expected v=%0b f=%0b m=%0d",
                     tg, i, gnt_valid[i], gnt_fail[i], gnt_mem[i*MW +: MW],
                     e.v[i], e.f[i], e.m[i*MW +: MW]);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  function automatic logic [P*TW-1:0] same_ts(input int t);
    logic [P*TW-1:0] r;
    for (int i = 0; i < P; i++) r[i*TW +: TW] = TW'(t);
    return r;
  endfunction

  initial begin
    logic [N*TW-1:0] rts;
    for (int m = 0; m < N; m++)
      for (int s = 0; s < SLOTS; s++) occ_m[m][s] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gnt_valid !== '0 || gnt_fail !== '0 || gnt_mem !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual v=%b f=%b m=%h expected all zero",
               gnt_valid, gnt_fail, gnt_mem);
    end
    @(negedge clk);
    rst = 1'b0;

    // Fresh table: lanes take memories 0..4 in order
    drive('1, same_ts(0), '0, '0, "R1 R3 R4 R9");
    // Same timestamp again: memories 5..8, lane 4 runs out
    drive('1, same_ts(0), '0, '0, "R5 R6 R8 R9");
    // Sparse lanes with a different timestamp
    drive(5'b01010, same_ts(5), '0, '0, "R2 R3");
    // Release of memory 2 at ts 0 in the same cycle as a request: still blocked
    rts = '0;
    drive(5'b00001, same_ts(0), 9'b000000100, rts, "R7 R8");
    // Retry now succeeds on memory 2
    drive(5'b00001, same_ts(0), '0, '0, "R7 R8");
    // Release of an already free slot changes nothing
    rts = '0; rts[7*TW +: TW] = TW'(9);
    drive(5'b00100, same_ts(9), 9'b010000000, rts, "R7");
    drive(5'b11111, same_ts(9), '0, '0, "R7 R4");
    drive('0, '0, '0, '0, "R2");

    // Pseudo-random mix with narrow timestamps
    for (int c = 0; c < 400; c++) begin
      logic [P-1:0]    v;
      logic [P*TW-1:0] ts;
      logic [N-1:0]    rv;
      logic [N*TW-1:0] rt;
      v = P'($urandom);
      for (int i = 0; i < P; i++) ts[i*TW +: TW] = TW'($urandom_range(0, 3));
      for (int m = 0; m < N; m++) begin
        rv[m] = ($urandom_range(0, 2) == 0);
        rt[m*TW +: TW] = TW'($urandom_range(0, 3));
      end
      drive(v, ts, rv, rt, "R2 R3 R4 R5 R6 R7 R8");
    end
    drive('0, '0, '0, '0, "R2");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    finish_run();
  end
endmodule